// File: doc/BRIEF.md
# Lane PLL Divider Search Engine

This block picks the input divider `n` and the feedback divider `m` of a lane PLL so that the lane bit rate it produces matches a target rate as closely as possible. The caller gives the reference clock frequency, the pixel clock in kHz, the number of data lanes and a pixel format code. The block first works out the lane rate the link needs. That rate is the per-lane pixel bandwidth with a 10/8 headroom factor. The block then searches the input dividers whose comparison frequency (reference / n) lies between 5 MHz and 40 MHz.

For each candidate `n`, the feedback divider is the whole quotient of the target rate by the comparison frequency. The block keeps the candidate that leaves the smallest remainder. It also reports the lane rate that the chosen pair gives and an escape-clock divider that keeps the escape clock at or below 20 MHz. A target rate of 1500 Mbps or more is refused with an error flag.

A one-cycle `start` launches a search. The block does all wide divisions one at a time on a single shared bit-serial divider. A search therefore takes from a few hundred to a few thousand cycles. A one-cycle `done` pulse marks the result, and the result outputs then hold until the next search completes.

Top module: `lane_pll_search`

## Requirements
- R1: The target rate is computed in this order, truncating at each step: T = ((pixKhz*1000 / laneCnt) * bpp / 8) * 10. Here bpp comes from pixFmt: code 0 gives 24, code 1 (18-bit colour, loosely packed) gives 24, code 2 (18-bit colour, packed) gives 18, and code 3 gives 16. laneCnt is 1 to 4.
- R2: If T >= 1500000000, rangeErr is 1 and nDiv, mDiv, laneHz and escDiv are all 0. Otherwise rangeErr is 0.
- R3: Candidates run downward from n = refHz / 5000000 while n > ceil(refHz / 40000000). For each candidate, pre = refHz / n and m = T / pre. A candidate replaces the best one only if m < 512 and T mod pre is strictly smaller than the best remainder so far. The best remainder starts at refHz. On a tie, the earlier (larger) n is kept.
- R4: The search stops as soon as the best remainder is 0. If no candidate is accepted, nDiv = 1 and mDiv = 1.
- R5: laneHz = (refHz / nDiv) * mDiv for the pair chosen. When no candidate is accepted, this is refHz.
- R6: escDiv = ceil(laneHz / 160000000).
- R7: done is high for exactly one cycle per search. The results are already valid in that cycle, and they stay unchanged until the next search completes.
- R8: A start pulse that arrives while a search is running is ignored. The running search completes with its own inputs.
- R9: After reset, done, rangeErr, nDiv, mDiv, laneHz and escDiv are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a search; the inputs are sampled in this cycle |
| refHz | input | 32 | Reference clock frequency in Hz |
| pixKhz | input | 32 | Pixel clock in kHz |
| laneCnt | input | 3 | Number of data lanes, 1 to 4 |
| pixFmt | input | 2 | Pixel format code (see R1) |
| done | output | 1 | One-cycle pulse marking a finished search |
| nDiv | output | 10 | Chosen input divider |
| mDiv | output | 9 | Chosen feedback divider |
| laneHz | output | 64 | Lane bit rate reached by the chosen pair |
| escDiv | output | 8 | Escape-clock divider |
| rangeErr | output | 1 | Target rate out of range |

## Verification
Every result of this block becomes valid in the cycle in which `done` is high. The number of cycles from `start` to `done` depends on how many candidates the search visits, since each division takes about 66 cycles. The bench therefore does not count a fixed latency. It waits at falling clock edges for `done`, with a per-search limit, and reads all five results in that same sample. One sample later it confirms that `done` has dropped. It then idles a further stretch of cycles and confirms that the results have not moved. For the busy case, a second `start` is placed a few cycles after the first, with different inputs on the pins. The result must still match the first set of inputs.

// File: rtl/lps_pkg.sv
package lps_pkg;

  typedef enum logic [2:0] {
    OP_LANE,
    OP_NHI,
    OP_NLO,
    OP_PRE,
    OP_M,
    OP_ESC
  } divOp_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_GO,
    S_WAIT,
    S_TEST,
    S_LOOP,
    S_EVAL,
    S_FIN
  } ctlState_t;

  typedef struct packed {
    logic   latch;
    logic   divGo;
    logic   setErr;
    logic   stepN;
    logic   finish;
    divOp_t op;
  } ctlStrobe_t;

  function automatic logic [4:0] bppOf(input logic [1:0] fmt);
    logic [4:0] b;
    case (fmt)
      2'd0:    b = 5'd24;
      2'd1:    b = 5'd24;
      2'd2:    b = 5'd18;
      default: b = 5'd16;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/lps_divider.sv
module lps_divider #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [DW-1:0] quo,
  output logic [DW-1:0] rem,
  output logic          divDone
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] quoR;
  logic [DW-1:0] remR;
  logic [DW-1:0] dsrR;
  logic [CW-1:0] cnt;
  logic          busy;
  logic          doneR;
  logic [DW:0]   trial;
  logic [DW:0]   diff;
  logic          fits;

  always_comb begin
    trial = {remR, quoR[DW-1]};
    diff  = trial - {1'b0, dsrR};
    fits  = (trial >= {1'b0, dsrR});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quoR  <= '0;
      remR  <= '0;
      dsrR  <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      doneR <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (go) begin
        quoR <= dividend;
        remR <= '0;
        dsrR <= divisor;
        cnt  <= CW'(DW);
        busy <= 1'b1;
      end else if (busy) begin
        remR <= fits ? diff[DW-1:0] : trial[DW-1:0];
        quoR <= {quoR[DW-2:0], fits};
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy  <= 1'b0;
          doneR <= 1'b1;
        end
      end
    end
  end

  assign quo     = quoR;
  assign rem     = remR;
  assign divDone = doneR;
endmodule

// File: rtl/lps_control.sv
module lps_control
  import lps_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       divDone,
  input  logic       tooFast,
  input  logic       candLive,
  input  logic       zeroRem,
  output ctlStrobe_t strb
);
  ctlState_t st, stNext;
  divOp_t    opR, opNext;

  always_comb begin
    strb    = '0;
    strb.op = opR;
    stNext  = st;
    opNext  = opR;
    case (st)
      S_IDLE: begin
        if (start) begin
          strb.latch = 1'b1;
          opNext     = OP_LANE;
          stNext     = S_GO;
        end
      end
      S_GO: begin
        strb.divGo = 1'b1;
        stNext     = S_WAIT;
      end
      S_WAIT: begin
        if (divDone) begin
          case (opR)
            OP_LANE: stNext = S_TEST;
            OP_NHI:  begin opNext = OP_NLO; stNext = S_GO; end
            OP_NLO:  stNext = S_LOOP;
            OP_PRE:  begin opNext = OP_M; stNext = S_GO; end
            OP_M:    stNext = S_EVAL;
            default: stNext = S_FIN;
          endcase
        end
      end
      S_TEST: begin
        if (tooFast) begin
          strb.setErr = 1'b1;
          stNext      = S_FIN;
        end else begin
          opNext = OP_NHI;
          stNext = S_GO;
        end
      end
      S_LOOP: begin
        opNext = candLive ? OP_PRE : OP_ESC;
        stNext = S_GO;
      end
      S_EVAL: begin
        if (zeroRem) begin
          opNext = OP_ESC;
          stNext = S_GO;
        end else begin
          strb.stepN = 1'b1;
          stNext     = S_LOOP;
        end
      end
      S_FIN: begin
        strb.finish = 1'b1;
        stNext      = S_IDLE;
      end
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st  <= S_IDLE;
      opR <= OP_LANE;
    end else begin
      st  <= stNext;
      opR <= opNext;
    end
  end
endmodule

// File: rtl/lps_datapath.sv
module lps_datapath
  import lps_pkg::*;
#(
  parameter int          REF_W       = 32,
  parameter int          PIX_W       = 32,
  parameter int          LANE_W      = 3,
  parameter int          RATE_W      = 64,
  parameter int          N_W         = 10,
  parameter int          M_W         = 9,
  parameter int          ESC_W       = 8,
  parameter int unsigned MAX_RATE_HZ = 1500000000,
  parameter int unsigned PRE_MIN_HZ  = 5000000,
  parameter int unsigned PRE_MAX_HZ  = 40000000,
  parameter int unsigned ESC_DEN_HZ  = 160000000,
  parameter int unsigned PIX_SCALE   = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [REF_W-1:0]  refHz,
  input  logic [PIX_W-1:0]  pixKhz,
  input  logic [LANE_W-1:0] laneCnt,
  input  logic [1:0]        pixFmt,
  output logic              divDone,
  output logic              tooFast,
  output logic              candLive,
  output logic              zeroRem,
  output logic              done,
  output logic [N_W-1:0]    nDiv,
  output logic [M_W-1:0]    mDiv,
  output logic [RATE_W-1:0] laneHz,
  output logic [ESC_W-1:0]  escDiv,
  output logic              rangeErr
);
  localparam int unsigned M_LIMIT = 1 << M_W;

  logic [RATE_W-1:0] refR, pixR, lanesR;
  logic [4:0]        bppR;
  logic [RATE_W-1:0] target, nCand, nLo, preCur;
  logic [RATE_W-1:0] bestRem, bestPre;
  logic [N_W-1:0]    bestN;
  logic [M_W-1:0]    bestM;
  logic [ESC_W-1:0]  escR;
  logic              errR;

  logic [RATE_W-1:0] dvdSel, dsrSel, divQ, divR;
  logic [RATE_W-1:0] laneW, headProd;

  always_comb begin
    laneW    = bestPre * RATE_W'(bestM);
    headProd = divQ * RATE_W'(bppR);
    case (strb.op)
      OP_LANE: begin dvdSel = pixR * RATE_W'(PIX_SCALE); dsrSel = lanesR; end
      OP_NHI:  begin dvdSel = refR; dsrSel = RATE_W'(PRE_MIN_HZ); end
      OP_NLO:  begin dvdSel = refR + RATE_W'(PRE_MAX_HZ) - 1'b1; dsrSel = RATE_W'(PRE_MAX_HZ); end
      OP_PRE:  begin dvdSel = refR; dsrSel = nCand; end
      OP_M:    begin dvdSel = target; dsrSel = preCur; end
      default: begin dvdSel = laneW; dsrSel = RATE_W'(ESC_DEN_HZ); end
    endcase
  end

  lps_divider #(.DW(RATE_W)) uDiv (
    .clk      (clk),
    .rstN     (rstN),
    .go       (strb.divGo),
    .dividend (dvdSel),
    .divisor  (dsrSel),
    .quo      (divQ),
    .rem      (divR),
    .divDone  (divDone)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refR <= '0; pixR <= '0; lanesR <= '0; bppR <= '0;
      target <= '0; nCand <= '0; nLo <= '0; preCur <= '0;
      bestRem <= '0; bestPre <= '0; bestN <= '0; bestM <= '0;
      escR <= '0; errR <= 1'b0;
      done <= 1'b0; nDiv <= '0; mDiv <= '0; laneHz <= '0;
      escDiv <= '0; rangeErr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strb.latch) begin
        refR    <= RATE_W'(refHz);
        pixR    <= RATE_W'(pixKhz);
        lanesR  <= RATE_W'(laneCnt);
        bppR    <= bppOf(pixFmt);
        bestRem <= RATE_W'(refHz);
        bestPre <= RATE_W'(refHz);
        bestN   <= N_W'(1);
        bestM   <= M_W'(1);
        escR    <= '0;
        errR    <= 1'b0;
      end
      if (divDone) begin
        case (strb.op)
          OP_LANE: target <= (headProd >> 3) * RATE_W'(10);
          OP_NHI:  nCand  <= divQ;
          OP_NLO:  nLo    <= divQ;
          OP_PRE:  preCur <= divQ;
          OP_M: begin
            if ((divQ < RATE_W'(M_LIMIT)) && (divR < bestRem)) begin
              bestRem <= divR;
              bestPre <= preCur;
              bestN   <= nCand[N_W-1:0];
              bestM   <= divQ[M_W-1:0];
            end
          end
          default: escR <= ESC_W'(divQ + RATE_W'(divR != '0));
        endcase
      end
      if (strb.setErr) errR <= 1'b1;
      if (strb.stepN) nCand <= nCand - 1'b1;
      if (strb.finish) begin
        done     <= 1'b1;
        rangeErr <= errR;
        nDiv     <= errR ? '0 : bestN;
        mDiv     <= errR ? '0 : bestM;
        laneHz   <= errR ? '0 : laneW;
        escDiv   <= errR ? '0 : escR;
      end
    end
  end

  assign tooFast  = (target >= RATE_W'(MAX_RATE_HZ));
  assign candLive = (nCand > nLo);
  assign zeroRem  = (bestRem == '0);
endmodule

// File: rtl/lane_pll_search.sv
module lane_pll_search
  import lps_pkg::*;
#(
  parameter int          REF_W       = 32,
  parameter int          PIX_W       = 32,
  parameter int          LANE_W      = 3,
  parameter int          RATE_W      = 64,
  parameter int          N_W         = 10,
  parameter int          M_W         = 9,
  parameter int          ESC_W       = 8,
  parameter int unsigned MAX_RATE_HZ = 1500000000,
  parameter int unsigned PRE_MIN_HZ  = 5000000,
  parameter int unsigned PRE_MAX_HZ  = 40000000,
  parameter int unsigned ESC_MAX_HZ  = 20000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [REF_W-1:0]  refHz,
  input  logic [PIX_W-1:0]  pixKhz,
  input  logic [LANE_W-1:0] laneCnt,
  input  logic [1:0]        pixFmt,
  output logic              done,
  output logic [N_W-1:0]    nDiv,
  output logic [M_W-1:0]    mDiv,
  output logic [RATE_W-1:0] laneHz,
  output logic [ESC_W-1:0]  escDiv,
  output logic              rangeErr
);
  localparam int unsigned ESC_DEN_HZ = 8 * ESC_MAX_HZ;

  ctlStrobe_t strb;
  logic       divDone, tooFast, candLive, zeroRem;

  lps_control uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .divDone  (divDone),
    .tooFast  (tooFast),
    .candLive (candLive),
    .zeroRem  (zeroRem),
    .strb     (strb)
  );

  lps_datapath #(
    .REF_W(REF_W), .PIX_W(PIX_W), .LANE_W(LANE_W), .RATE_W(RATE_W),
    .N_W(N_W), .M_W(M_W), .ESC_W(ESC_W), .MAX_RATE_HZ(MAX_RATE_HZ),
    .PRE_MIN_HZ(PRE_MIN_HZ), .PRE_MAX_HZ(PRE_MAX_HZ),
    .ESC_DEN_HZ(ESC_DEN_HZ), .PIX_SCALE(1000)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .refHz    (refHz),
    .pixKhz   (pixKhz),
    .laneCnt  (laneCnt),
    .pixFmt   (pixFmt),
    .divDone  (divDone),
    .tooFast  (tooFast),
    .candLive (candLive),
    .zeroRem  (zeroRem),
    .done     (done),
    .nDiv     (nDiv),
    .mDiv     (mDiv),
    .laneHz   (laneHz),
    .escDiv   (escDiv),
    .rangeErr (rangeErr)
  );
endmodule

// File: rtl/lane_pll_search_chk.sv
module lane_pll_search_chk #(
  parameter int          RATE_W     = 64,
  parameter int          N_W        = 10,
  parameter int          M_W        = 9,
  parameter int          ESC_W      = 8,
  parameter int unsigned ESC_MAX_HZ = 20000000
) (
  input logic              clk,
  input logic              rstN,
  input logic              done,
  input logic [N_W-1:0]    nDiv,
  input logic [M_W-1:0]    mDiv,
  input logic [RATE_W-1:0] laneHz,
  input logic [ESC_W-1:0]  escDiv,
  input logic              rangeErr
);
  localparam logic [RATE_W-1:0] ESC_DEN = RATE_W'(8 * ESC_MAX_HZ);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable({nDiv, mDiv, laneHz, escDiv, rangeErr})); // R7

  AST_ERR_ZEROS: assert property (@(posedge clk) disable iff (!rstN)
    (done && rangeErr) |-> (nDiv == '0 && mDiv == '0 && laneHz == '0 && escDiv == '0)); // R2

  AST_DIVIDERS_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (done && !rangeErr) |-> (nDiv != '0 && mDiv != '0)); // R4

  AST_ESC_COVERS_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (done && !rangeErr) |-> (RATE_W'(escDiv) * ESC_DEN >= laneHz)); // R6

  AST_ESC_TIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (done && !rangeErr) |-> (RATE_W'(escDiv - 1'b1) * ESC_DEN < laneHz)); // R6
endmodule

bind lane_pll_search lane_pll_search_chk #(
  .RATE_W(RATE_W), .N_W(N_W), .M_W(M_W), .ESC_W(ESC_W), .ESC_MAX_HZ(ESC_MAX_HZ)
) u_chk (.*);

// File: tb/sim_lane_pll_search.sv
`timescale 1ns/1ps
module sim_lane_pll_search;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] refHz = '0;
  logic [31:0] pixKhz = '0;
  logic [2:0]  laneCnt = 3'd1;
  logic [1:0]  pixFmt = 2'd0;
  logic        done;
  logic [9:0]  nDiv;
  logic [8:0]  mDiv;
  logic [63:0] laneHz;
  logic [7:0]  escDiv;
  logic        rangeErr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lane_pll_search u0 (
    .clk(clk), .rstN(rstN), .start(start), .refHz(refHz), .pixKhz(pixKhz),
    .laneCnt(laneCnt), .pixFmt(pixFmt), .done(done), .nDiv(nDiv), .mDiv(mDiv),
    .laneHz(laneHz), .escDiv(escDiv), .rangeErr(rangeErr)
  );

  task automatic check64(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Expected values from the requirements (R1..R6)
  task automatic model(input logic [63:0] r, input logic [63:0] pk,
                       input logic [63:0] ln, input logic [1:0] fmt,
                       output logic [63:0] eN, output logic [63:0] eM,
                       output logic [63:0] eLane, output logic [63:0] eEsc,
                       output logic eErr);
    logic [63:0] t, bpp, best, bpre, lo, p;
    bpp = (fmt == 2'd2) ? 64'd18 : (fmt == 2'd3) ? 64'd16 : 64'd24;
    t = (pk * 64'd1000) / ln;
    t = t * bpp;
    t = t / 64'd8;
    t = t * 64'd10;
    eErr = (t >= 64'd1500000000);
    eN = 64'd1; eM = 64'd1; best = r; bpre = r;
    lo = (r + 64'd39999999) / 64'd40000000;
    for (logic [63:0] i = r / 64'd5000000; i > lo; i--) begin
      p = r / i;
      if ((t % p) < best && (t / p) < 64'd512) begin
        best = t % p; eN = i; eM = t / p; bpre = p;
      end
      if (best == 64'd0) break;
    end
    eLane = bpre * eM;
    eEsc = (eLane + 64'd159999999) / 64'd160000000;
    if (eErr) begin eN = 0; eM = 0; eLane = 0; eEsc = 0; end
  endtask

  task automatic pulseStart(input logic [31:0] r, input logic [31:0] pk,
                            input logic [2:0] ln, input logic [1:0] fmt);
    @(negedge clk);
    refHz = r; pixKhz = pk; laneCnt = ln; pixFmt = fmt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (!done && n < 40000) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL %s done: actual 0 expected 1 (timeout)", tag);
    end
  endtask

  task automatic compare(input string tag, input logic [31:0] r, input logic [31:0] pk,
                         input logic [2:0] ln, input logic [1:0] fmt);
    logic [63:0] eN, eM, eLane, eEsc;
    logic eErr;
    model(r, pk, 64'(ln), fmt, eN, eM, eLane, eEsc, eErr);
    check64(tag, "rangeErr R2", 64'(rangeErr), 64'(eErr));
    check64(tag, "nDiv R3", 64'(nDiv), eN);
    check64(tag, "mDiv R3", 64'(mDiv), eM);
    check64(tag, "laneHz R5", laneHz, eLane);
    check64(tag, "escDiv R6", 64'(escDiv), eEsc);
  endtask

  task automatic runCase(input string tag, input logic [31:0] r, input logic [31:0] pk,
                         input logic [2:0] ln, input logic [1:0] fmt);
    pulseStart(r, pk, ln, fmt);
    waitDone(tag);
    compare(tag, r, pk, ln, fmt);
    @(negedge clk);
    check64(tag, "done pulse width R7", 64'(done), 64'd0);
  endtask

  task automatic tReset();
    check64("R9", "done", 64'(done), 0);
    check64("R9", "nDiv", 64'(nDiv), 0);
    check64("R9", "mDiv", 64'(mDiv), 0);
    check64("R9", "laneHz", laneHz, 0);
    check64("R9", "escDiv", 64'(escDiv), 0);
    check64("R9", "rangeErr", 64'(rangeErr), 0);
  endtask

  task automatic tBasic();
    runCase("R1 24MHz 4-lane fmt0", 32'd24000000, 32'd150000, 3'd4, 2'd0);
    check64("R3", "nDiv fixed", 64'(nDiv), 64'd4);
    check64("R3", "mDiv fixed", 64'(mDiv), 64'd187);
    check64("R5", "laneHz fixed", laneHz, 64'd1122000000);
    check64("R6", "escDiv fixed", 64'(escDiv), 64'd8);
  endtask

  task automatic tFormats();
    runCase("R1 fmt1", 32'd24000000, 32'd100000, 3'd3, 2'd1);
    runCase("R1 fmt2", 32'd24000000, 32'd100000, 3'd3, 2'd2);
    runCase("R1 fmt3", 32'd24000000, 32'd70000, 3'd1, 2'd3);
    runCase("R1 2-lane fmt0", 32'd27000000, 32'd74250, 3'd2, 2'd0);
  endtask

  task automatic tErrBoundary();
    runCase("R2 at limit", 32'd24000000, 32'd200000, 3'd4, 2'd0);
    check64("R2", "rangeErr at 1500M", 64'(rangeErr), 64'd1);
    runCase("R2 below limit", 32'd24000000, 32'd199999, 3'd4, 2'd0);
    check64("R2", "rangeErr below 1500M", 64'(rangeErr), 64'd0);
  endtask

  task automatic tTie();
    runCase("R4 zero remainder tie", 32'd24000000, 32'd160000, 3'd4, 2'd0);
    check64("R4", "nDiv keeps larger n", 64'(nDiv), 64'd4);
    check64("R4", "mDiv", 64'(mDiv), 64'd200);
  endtask

  task automatic tNoCandidate();
    runCase("R4 empty band", 32'd9000000, 32'd50000, 3'd2, 2'd3);
    check64("R4", "nDiv default", 64'(nDiv), 64'd1);
    check64("R4", "mDiv default", 64'(mDiv), 64'd1);
    check64("R5", "laneHz equals ref", laneHz, 64'd9000000);
  endtask

  task automatic tWideBand();
    runCase("R3 100MHz ref", 32'd100000000, 32'd148500, 3'd4, 2'd0);
    runCase("R3 52MHz ref", 32'd52000000, 32'd65000, 3'd2, 2'd2);
  endtask

  task automatic tBusyIgnore();
    pulseStart(32'd24000000, 32'd150000, 3'd4, 2'd0);
    repeat (10) @(negedge clk);
    refHz = 32'd100000000; pixKhz = 32'd30000; laneCnt = 3'd1; pixFmt = 2'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone("R8");
    compare("R8 busy start ignored", 32'd24000000, 32'd150000, 3'd4, 2'd0);
    @(negedge clk);
    repeat (300) begin
      @(negedge clk);
      if (done) begin
        checks++; errors++;
        $display("FAIL R8 extra done: actual 1 expected 0");
        break;
      end
    end
  endtask

  task automatic tHold();
    logic [63:0] l0;
    logic [9:0]  n0;
    runCase("R7 hold", 32'd24000000, 32'd120000, 3'd4, 2'd0);
    l0 = laneHz; n0 = nDiv;
    refHz = 32'd50000000; pixKhz = 32'd1000;
    repeat (200) @(negedge clk);
    check64("R7", "laneHz held", laneHz, l0);
    check64("R7", "nDiv held", 64'(nDiv), 64'(n0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tBasic();
    tFormats();
    tErrBoundary();
    tTie();
    tNoCandidate();
    tWideBand();
    tBusyIgnore();
    tHold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule